// File: doc/BRIEF.md
# Rolling-Shutter Line Sequencer

This block drives the row side of a directly addressed image sensor that runs an electronic rolling shutter. For each line request it puts the row to be read on the address bus and strobes it in with an active-low load pulse. It then issues the sample pulse, the reset pulse and the second sample pulse that together form double sampling. After that it addresses a second row, a programmable number of lines ahead in the window, and resets it. The distance between the read row and the reset row sets the integration time in whole line periods. On the first line of each frame it also issues a calibration pulse inside the signal-sample pulse.

The window is given as a first row, a last row and a row step for subsampling. The window, step and integration offset are sampled only when a frame starts, so they can be changed freely in the middle of a frame. Every width and delay is a parameter counted in system-clock cycles. The defaults assume a 5 ns clock and round each minimum up. A one-cycle line-done pulse marks the moment the column readout may begin. A busy flag shows when a new line request will be accepted.

Top module: `rs_line_seq`

## Requirements
- R1: After reset the load strobe is high, the sample, reset, calibration and line-done outputs are low, busy is low and the address bus is zero.
- R2: Address bus pin k carries row bit ROW_W-1-k, so pin 0 holds the MSB and pin ROW_W-1 holds the LSB.
- R3: Each row address is driven SETUP_CYC cycles before the load strobe falls. The strobe stays low for LOAD_CYC cycles, and the address does not change while it is low.
- R4: The signal-sample pulse falls exactly SETTLE_CYC cycles after the read-row strobe rises. The signal-sample and reset-sample pulses are each SAMP_CYC cycles wide and never overlap a load strobe or a reset pulse.
- R5: The read-row reset pulse rises in the cycle that follows the last high cycle of the signal-sample pulse and lasts RST_CYC cycles. The reset-sample pulse falls exactly RST2R_CYC cycles after this reset pulse falls.
- R6: Line-done is high for exactly one cycle, the first cycle after the reset-sample pulse falls.
- R7: Within a frame, line i reads row first + i*step (step 0 counts as 1). The line count is H = (last-first)/step + 1 when last >= first and 1 otherwise. After H lines the next line starts a new frame.
- R8: When the offset is nonzero and below H, the reset row first + ((i+offset) mod H)*step is put on the bus in the line-done cycle. It is loaded with a second strobe of the same shape. Its reset pulse rises LD2RST_CYC cycles after that strobe rises and lasts RST_CYC cycles. Busy falls AHOLD_CYC cycles after this reset pulse ends.
- R9: An offset of zero or of H or more issues no second strobe and no second reset, and busy falls in the line-done cycle.
- R10: Only on the first line of a frame, a calibration pulse rises CAL_DLY_CYC cycles after the signal-sample pulse rises and lasts CAL_W_CYC cycles.
- R11: Window, step and offset are taken only on the first line of a frame. Changes on later lines take effect at the next frame.
- R12: A line request while busy is high is ignored. It starts no line and does not advance the row sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_req_i | input | 1 | Start one line when not busy |
| win_first_i | input | ROW_W | First row of the window |
| win_last_i | input | ROW_W | Last row of the window |
| row_step_i | input | STEP_W | Row step for subsampling (0 acts as 1) |
| int_offset_i | input | ROW_W | Integration offset in lines |
| row_bus_o | output | ROW_W | Row address bus, pin 0 carries the MSB |
| row_load_n_o | output | 1 | Active-low address load strobe |
| samp_sig_o | output | 1 | Signal-level sample pulse |
| samp_rst_o | output | 1 | Reset-level sample pulse |
| row_reset_o | output | 1 | Row reset pulse |
| cal_o | output | 1 | Once-per-frame calibration pulse |
| line_done_o | output | 1 | One-cycle pulse: column readout may start |
| busy_o | output | 1 | A line sequence is in progress |

## Verification
Two functions can fall on the same cycle. The line-done pulse coincides with the first cycle of the reset-row address setup. On the first line of a frame, the calibration pulse runs while the signal-sample pulse is high. The bench sweeps several windows, steps and offsets, including wrap of the reset row past the window end and offsets that suppress the reset row. For every line it records the cycle of each edge and compares it with positions computed from the parameters. It also injects a line request while busy is high and checks that it changes neither the running line nor the next row.

// File: rtl/rs_line_pkg.sv
`timescale 1ns/1ps
package rs_line_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_A_SET,
      PH_A_LD,
      PH_A_WAIT,
      PH_S,
      PH_RST1,
      PH_GAP,
      PH_R,
      PH_B_SET,
      PH_B_LD,
      PH_B_WAIT,
      PH_RST2,
      PH_POST
   } rs_phase_e;

   // successor of a phase once its count has run out
   function automatic rs_phase_e rs_next_phase(rs_phase_e p, logic second_row);
      case (p)
         PH_A_SET:  rs_next_phase = PH_A_LD;
         PH_A_LD:   rs_next_phase = PH_A_WAIT;
         PH_A_WAIT: rs_next_phase = PH_S;
         PH_S:      rs_next_phase = PH_RST1;
         PH_RST1:   rs_next_phase = PH_GAP;
         PH_GAP:    rs_next_phase = PH_R;
         PH_R:      rs_next_phase = second_row ? PH_B_SET : PH_IDLE;
         PH_B_SET:  rs_next_phase = PH_B_LD;
         PH_B_LD:   rs_next_phase = PH_B_WAIT;
         PH_B_WAIT: rs_next_phase = PH_RST2;
         PH_RST2:   rs_next_phase = PH_POST;
         default:   rs_next_phase = PH_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/rs_row_track.sv
`timescale 1ns/1ps
module rs_row_track #(
   parameter int ROW_W  = 10,
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [ROW_W-1:0]  first_row_i,
   input  logic [ROW_W-1:0]  last_row_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic [ROW_W-1:0]  offset_i,
   output logic [ROW_W-1:0]  read_row_o,
   output logic [ROW_W-1:0]  rst_row_o,
   output logic              rst_en_o,
   output logic              line_first_o
);
   localparam int HW = ROW_W + 1;
   localparam int PW = ROW_W + STEP_W + 1;

   logic [ROW_W-1:0]  idx_q, first_q, off_q;
   logic [STEP_W-1:0] step_q;
   logic [HW-1:0]     h_q;

   logic [STEP_W-1:0] live_step, e_step;
   logic [HW-1:0]     live_h, e_h, sum, ridx;
   logic [PW-1:0]     span, rd_full, rs_full;
   logic [ROW_W-1:0]  e_first, e_off, nxt_idx;
   logic              at_start, e_rst_en;

   assign at_start = (idx_q == '0);

   always_comb begin
      live_step = (step_i == '0) ? STEP_W'(1) : step_i;
      span      = PW'(last_row_i) - PW'(first_row_i);
      if (last_row_i >= first_row_i)
         live_h = HW'(span / PW'(live_step)) + HW'(1);
      else
         live_h = HW'(1);
   end

   // frame configuration: live inputs on the first line, latched copy after
   always_comb begin
      e_first  = at_start ? first_row_i : first_q;
      e_step   = at_start ? live_step   : step_q;
      e_h      = at_start ? live_h      : h_q;
      e_off    = at_start ? offset_i    : off_q;
      sum      = HW'(idx_q) + HW'(e_off);
      e_rst_en = (e_off != '0) && (HW'(e_off) < e_h);
      ridx     = (sum >= e_h) ? (sum - e_h) : sum;
      rd_full  = PW'(e_first) + PW'(idx_q) * PW'(e_step);
      rs_full  = PW'(e_first) + PW'(ridx) * PW'(e_step);
      nxt_idx  = ((HW'(idx_q) + HW'(1)) == e_h) ? '0 : (idx_q + ROW_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q        <= '0;
         first_q      <= '0;
         off_q        <= '0;
         step_q       <= STEP_W'(1);
         h_q          <= HW'(1);
         read_row_o   <= '0;
         rst_row_o    <= '0;
         rst_en_o     <= 1'b0;
         line_first_o <= 1'b0;
      end else if (accept_i) begin
         idx_q        <= nxt_idx;
         first_q      <= e_first;
         off_q        <= e_off;
         step_q       <= e_step;
         h_q          <= e_h;
         read_row_o   <= rd_full[ROW_W-1:0];
         rst_row_o    <= rs_full[ROW_W-1:0];
         rst_en_o     <= e_rst_en;
         line_first_o <= at_start;
      end
   end

   a_r7_read_row_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      read_row_o >= first_q);

   a_r8_rst_row_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      rst_en_o |-> (rst_row_o >= first_q));

endmodule

// File: rtl/rs_phase_ctrl.sv
`timescale 1ns/1ps
module rs_phase_ctrl
   import rs_line_pkg::*;
#(
   parameter int SETUP_CYC   = 2,
   parameter int LOAD_CYC    = 4,
   parameter int SETTLE_CYC  = 720,
   parameter int SAMP_CYC    = 80,
   parameter int RST_CYC     = 40,
   parameter int RST2R_CYC   = 320,
   parameter int LD2RST_CYC  = 20,
   parameter int AHOLD_CYC   = 20,
   parameter int CAL_DLY_CYC = 30,
   parameter int CAL_W_CYC   = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_req_i,
   input  logic rst_en_i,
   input  logic line_first_i,
   output logic accept_o,
   output logic phase_b_o,
   output logic load_n_o,
   output logic samp_s_o,
   output logic samp_r_o,
   output logic row_rst_o,
   output logic cal_o,
   output logic line_done_o,
   output logic busy_o
);
   localparam int LONGEST = SETUP_CYC + LOAD_CYC + SETTLE_CYC + SAMP_CYC + RST_CYC
                          + RST2R_CYC + LD2RST_CYC + AHOLD_CYC;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam int CAL_END = CAL_DLY_CYC + CAL_W_CYC;
   localparam int CAL_CW  = $clog2(CAL_END + 1);

   rs_phase_e        ph_q, ph_d, ph_succ;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CAL_CW-1:0] cal_cnt_q;
   logic             cal_run_q, cal_start;

   function automatic logic [CNT_W-1:0] len_of(rs_phase_e p);
      case (p)
         PH_A_SET, PH_B_SET: len_of = CNT_W'(SETUP_CYC);
         PH_A_LD,  PH_B_LD:  len_of = CNT_W'(LOAD_CYC);
         PH_A_WAIT:          len_of = CNT_W'(SETTLE_CYC - SAMP_CYC);
         PH_S, PH_R:         len_of = CNT_W'(SAMP_CYC);
         PH_RST1, PH_RST2:   len_of = CNT_W'(RST_CYC);
         PH_GAP:             len_of = CNT_W'(RST2R_CYC - SAMP_CYC);
         PH_B_WAIT:          len_of = CNT_W'(LD2RST_CYC);
         PH_POST:            len_of = CNT_W'(AHOLD_CYC);
         default:            len_of = CNT_W'(1);
      endcase
   endfunction

   assign ph_succ = rs_next_phase(ph_q, rst_en_i);

   always_comb begin
      ph_d     = ph_q;
      cnt_d    = cnt_q;
      accept_o = 1'b0;
      if (ph_q == PH_IDLE) begin
         if (line_req_i) begin
            accept_o = 1'b1;
            ph_d     = PH_A_SET;
            cnt_d    = len_of(PH_A_SET) - CNT_W'(1);
         end
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - CNT_W'(1);
      end else begin
         ph_d  = ph_succ;
         cnt_d = len_of(ph_succ) - CNT_W'(1);
      end
   end

   assign cal_start = (ph_q == PH_A_WAIT) && (cnt_q == '0) && line_first_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_IDLE;
         cnt_q       <= '0;
         line_done_o <= 1'b0;
         cal_run_q   <= 1'b0;
         cal_cnt_q   <= '0;
      end else begin
         ph_q        <= ph_d;
         cnt_q       <= cnt_d;
         line_done_o <= (ph_q == PH_R) && (cnt_q == '0);
         if (cal_start) begin
            cal_run_q <= 1'b1;
            cal_cnt_q <= '0;
         end else if (cal_run_q) begin
            if (cal_cnt_q == CAL_CW'(CAL_END - 1)) cal_run_q <= 1'b0;
            cal_cnt_q <= cal_cnt_q + CAL_CW'(1);
         end
      end
   end

   assign load_n_o  = !((ph_q == PH_A_LD) || (ph_q == PH_B_LD));
   assign samp_s_o  = (ph_q == PH_S);
   assign samp_r_o  = (ph_q == PH_R);
   assign row_rst_o = (ph_q == PH_RST1) || (ph_q == PH_RST2);
   assign busy_o    = (ph_q != PH_IDLE);
   assign phase_b_o = (ph_q == PH_B_SET) || (ph_q == PH_B_LD) || (ph_q == PH_B_WAIT)
                   || (ph_q == PH_RST2)  || (ph_q == PH_POST);
   assign cal_o     = cal_run_q && (cal_cnt_q >= CAL_CW'(CAL_DLY_CYC));

   a_r4_sample_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_s_o || samp_r_o) |-> (load_n_o && !row_rst_o && !(samp_s_o && samp_r_o)));

   a_r5_reset_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(samp_s_o) |-> row_rst_o);

   a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      line_done_o |=> !line_done_o);

   a_r9_second_row_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      phase_b_o |-> rst_en_i);

   a_r10_cal_first_line: assert property (@(posedge clk) disable iff (!rst_n)
      cal_o |-> line_first_i);

   a_r12_busy_holds_request: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && line_req_i) |-> !accept_o);

endmodule

// File: rtl/rs_bus_order.sv
`timescale 1ns/1ps
module rs_bus_order #(
   parameter int ROW_W    = 10,
   parameter bit PIN0_MSB = 1'b1
) (
   input  logic [ROW_W-1:0] row_i,
   output logic [ROW_W-1:0] bus_o
);
   generate
      if (PIN0_MSB) begin : g_msb_first
         for (genvar g = 0; g < ROW_W; g++) begin : g_pin
            assign bus_o[g] = row_i[ROW_W-1-g];
         end
      end else begin : g_lsb_first
         assign bus_o = row_i;
      end
   endgenerate
endmodule

// File: rtl/rs_line_seq.sv
`timescale 1ns/1ps
module rs_line_seq #(
   parameter int ROW_W       = 10,
   parameter int STEP_W      = 3,
   parameter bit PIN0_MSB    = 1'b1,
   parameter int SETUP_CYC   = 2,
   parameter int LOAD_CYC    = 4,
   parameter int SETTLE_CYC  = 720,
   parameter int SAMP_CYC    = 80,
   parameter int RST_CYC     = 40,
   parameter int RST2R_CYC   = 320,
   parameter int LD2RST_CYC  = 20,
   parameter int AHOLD_CYC   = 20,
   parameter int CAL_DLY_CYC = 30,
   parameter int CAL_W_CYC   = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_req_i,
   input  logic [ROW_W-1:0]  win_first_i,
   input  logic [ROW_W-1:0]  win_last_i,
   input  logic [STEP_W-1:0] row_step_i,
   input  logic [ROW_W-1:0]  int_offset_i,
   output logic [ROW_W-1:0]  row_bus_o,
   output logic              row_load_n_o,
   output logic              samp_sig_o,
   output logic              samp_rst_o,
   output logic              row_reset_o,
   output logic              cal_o,
   output logic              line_done_o,
   output logic              busy_o
);
   generate
      if (SETUP_CYC < 1 || LOAD_CYC < 1 || SAMP_CYC < 1 || RST_CYC < 1 ||
          LD2RST_CYC < 1 || AHOLD_CYC < 1 || CAL_W_CYC < 1 || CAL_DLY_CYC < 0) begin : g_bad_len
         $error("rs_line_seq: every pulse and delay needs at least one cycle");
      end
      if (SETTLE_CYC <= SAMP_CYC || SETTLE_CYC < LD2RST_CYC) begin : g_bad_settle
         $error("rs_line_seq: settle time must exceed sample width and load-to-reset delay");
      end
      if (RST2R_CYC <= SAMP_CYC || RST2R_CYC < AHOLD_CYC) begin : g_bad_r
         $error("rs_line_seq: reset-to-R delay too short for sample width or address hold");
      end
      if (ROW_W < 2 || STEP_W < 1) begin : g_bad_width
         $error("rs_line_seq: bad address or step width");
      end
   endgenerate

   logic             accept, phase_b, rst_en, line_first;
   logic [ROW_W-1:0] read_row, rst_row, cur_row;

   rs_row_track #(.ROW_W(ROW_W), .STEP_W(STEP_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .first_row_i (win_first_i),
      .last_row_i  (win_last_i),
      .step_i      (row_step_i),
      .offset_i    (int_offset_i),
      .read_row_o  (read_row),
      .rst_row_o   (rst_row),
      .rst_en_o    (rst_en),
      .line_first_o(line_first)
   );

   rs_phase_ctrl #(
      .SETUP_CYC  (SETUP_CYC),
      .LOAD_CYC   (LOAD_CYC),
      .SETTLE_CYC (SETTLE_CYC),
      .SAMP_CYC   (SAMP_CYC),
      .RST_CYC    (RST_CYC),
      .RST2R_CYC  (RST2R_CYC),
      .LD2RST_CYC (LD2RST_CYC),
      .AHOLD_CYC  (AHOLD_CYC),
      .CAL_DLY_CYC(CAL_DLY_CYC),
      .CAL_W_CYC  (CAL_W_CYC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_req_i  (line_req_i),
      .rst_en_i    (rst_en),
      .line_first_i(line_first),
      .accept_o    (accept),
      .phase_b_o   (phase_b),
      .load_n_o    (row_load_n_o),
      .samp_s_o    (samp_sig_o),
      .samp_r_o    (samp_rst_o),
      .row_rst_o   (row_reset_o),
      .cal_o       (cal_o),
      .line_done_o (line_done_o),
      .busy_o      (busy_o)
   );

   assign cur_row = phase_b ? rst_row : read_row;

   rs_bus_order #(.ROW_W(ROW_W), .PIN0_MSB(PIN0_MSB)) u_order (
      .row_i(cur_row),
      .bus_o(row_bus_o)
   );

   a_r3_addr_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_load_n_o && !$past(row_load_n_o)) |-> $stable(row_bus_o));

endmodule

// File: tb/rs_line_seq_bench.sv
`timescale 1ns/1ps
module rs_line_seq_bench;
   localparam int RW = 10;
   localparam int SW = 3;
   localparam int SU = 2, LD = 3, SETTLE = 12, SAMP = 3, RST = 2, RST2R = 6;
   localparam int L2R = 3, AH = 2, CD = 2, CW = 2;
   localparam int S_RISE = SU + LD + SETTLE - SAMP + 1;
   localparam int RST1_K = S_RISE + SAMP;
   localparam int R_RISE = S_RISE + RST + RST2R;
   localparam int DONE_K = R_RISE + SAMP;

   logic clk = 1'b0, rst_n = 1'b0, line_req = 1'b0;
   logic [RW-1:0] w_first = '0, w_last = '0, offs = '0;
   logic [SW-1:0] w_step = '0;
   logic [RW-1:0] bus;
   logic ld_n, s_o, r_o, rst_o, cal, done, busy;

   int tests = 0, fails = 0;
   int m_idx = 0, m_first = 0, m_step = 1, m_h = 1, m_off = 0;

   always #2.5 clk = ~clk;

   rs_line_seq #(
      .ROW_W(RW), .STEP_W(SW), .SETUP_CYC(SU), .LOAD_CYC(LD), .SETTLE_CYC(SETTLE),
      .SAMP_CYC(SAMP), .RST_CYC(RST), .RST2R_CYC(RST2R), .LD2RST_CYC(L2R),
      .AHOLD_CYC(AH), .CAL_DLY_CYC(CD), .CAL_W_CYC(CW)
   ) u_rs_line_seq (
      .clk(clk), .rst_n(rst_n), .line_req_i(line_req), .win_first_i(w_first),
      .win_last_i(w_last), .row_step_i(w_step), .int_offset_i(offs),
      .row_bus_o(bus), .row_load_n_o(ld_n), .samp_sig_o(s_o), .samp_rst_o(r_o),
      .row_reset_o(rst_o), .cal_o(cal), .line_done_o(done), .busy_o(busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int rev(input int v);
      int r = 0;
      for (int b = 0; b < RW; b++) if (v[b]) r[RW-1-b] = 1'b1;
      return r;
   endfunction

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   // one line: model expectation, stimulus, per-cycle edge capture, checks
   task automatic run_line(input int inj);
      int exp_rd, exp_rs, ridx, k, nld, nrst, s_hi, r_hi, rst_hi, cal_hi, done_hi;
      int ldf0, ldf1, ldr0, s_rise, s_fall, r_rise, rr0, rr1, cal_rise, done_k, end_k, bad;
      int ad0, ad1;
      bit en, first;
      logic p_ld, p_s, p_r, p_rst, p_cal;
      if (m_idx == 0) begin
         m_first = w_first;
         m_step  = (w_step == 0) ? 1 : int'(w_step);
         m_h     = (w_last >= w_first) ? (int'(w_last) - int'(w_first)) / m_step + 1 : 1;
         m_off   = offs;
      end
      first  = (m_idx == 0);
      en     = (m_off != 0) && (m_off < m_h);
      exp_rd = m_first + m_idx * m_step;
      ridx   = (m_idx + m_off) % m_h;
      exp_rs = m_first + ridx * m_step;
      m_idx  = (m_idx + 1) % m_h;

      nld = 0; nrst = 0; s_hi = 0; r_hi = 0; rst_hi = 0; cal_hi = 0; done_hi = 0;
      ldf0 = -1; ldf1 = -1; ldr0 = -1; s_rise = -1; s_fall = -1; r_rise = -1;
      rr0 = -1; rr1 = -1; cal_rise = -1; done_k = -1; end_k = -1; bad = 0; ad0 = -1; ad1 = -1;
      p_ld = 1'b1; p_s = 1'b0; p_r = 1'b0; p_rst = 1'b0; p_cal = 1'b0;

      @(negedge clk);
      chk("R12 idle before request", int'(busy), 0);
      line_req = 1'b1;
      @(negedge clk);
      line_req = 1'b0;
      k = 1;
      while (k < 2000) begin
         if (p_ld && !ld_n) begin
            if (nld == 0) begin ldf0 = k; ad0 = bus; end
            if (nld == 1) begin ldf1 = k; ad1 = bus; end
            nld++;
         end
         if (!ld_n && nld == 1 && int'(bus) != ad0) bad++;
         if (!ld_n && nld == 2 && int'(bus) != ad1) bad++;
         if (!p_ld && ld_n && ldr0 < 0) ldr0 = k;
         if (!p_s && s_o) s_rise = k;
         if (p_s && !s_o) s_fall = k;
         if (s_o) s_hi++;
         if (!p_r && r_o) r_rise = k;
         if (r_o) r_hi++;
         if (!p_rst && rst_o) begin
            if (nrst == 0) rr0 = k;
            if (nrst == 1) rr1 = k;
            nrst++;
         end
         if (rst_o) rst_hi++;
         if (!p_cal && cal) cal_rise = k;
         if (cal) cal_hi++;
         if (done) begin if (done_k < 0) done_k = k; done_hi++; end
         p_ld = ld_n; p_s = s_o; p_r = r_o; p_rst = rst_o; p_cal = cal;
         if (!busy) begin end_k = k; break; end
         line_req = (k == inj);
         @(negedge clk);
         line_req = 1'b0;
         k++;
      end

      chk("R3 strobe count", nld, en ? 2 : 1);
      chk("R3 read strobe falls after setup", ldf0, SU + 1);
      chk("R3 read strobe width", ldr0 - ldf0, LD);
      chk("R3 address stable while strobe low", bad, 0);
      chk("R2 R7 read row on bus", ad0, rev(exp_rd));
      chk("R4 sample-signal rise", s_rise, S_RISE);
      chk("R4 sample-signal width", s_hi, SAMP);
      chk("R4 strobe rise to sample fall", s_fall - ldr0, SETTLE);
      chk("R4 reset-sample width", r_hi, SAMP);
      chk("R5 read-row reset rise", rr0, RST1_K);
      chk("R5 reset pulse total width", rst_hi, en ? 2 * RST : RST);
      chk("R5 reset fall to R fall", (r_rise + SAMP) - (rr0 + RST), RST2R);
      chk("R6 line-done cycle", done_k, DONE_K);
      chk("R6 line-done width", done_hi, 1);
      if (en) begin
         chk("R8 reset-row strobe", ldf1, DONE_K + SU);
         chk("R8 reset row on bus", ad1, rev(exp_rs));
         chk("R8 second reset rise", rr1, ldf1 + LD + L2R);
         chk("R8 busy end after hold", end_k, rr1 + RST + AH);
      end else begin
         chk("R9 single reset pulse", nrst, 1);
         chk("R9 busy ends with line-done", end_k, DONE_K);
      end
      if (first) begin
         chk("R10 cal rise", cal_rise, S_RISE + CD);
         chk("R10 cal width", cal_hi, CW);
      end else begin
         chk("R10 no cal off first line", cal_hi, 0);
      end
      if (inj > 0) begin
         repeat (3) @(negedge clk);
         chk("R12 ignored request starts nothing", int'(busy), 0);
      end
   endtask

   task automatic set_cfg(input int f, input int l, input int st, input int o);
      w_first = RW'(f); w_last = RW'(l); w_step = SW'(st); offs = RW'(o);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 load strobe idle high", int'(ld_n), 1);
      chk("R1 pulses low", int'(s_o | r_o | rst_o | cal | done), 0);
      chk("R1 busy low", int'(busy), 0);
      chk("R1 bus zero", int'(bus), 0);
      rst_n = 1'b1;

      // 8-line window, offset wraps past the window end
      set_cfg(5, 12, 1, 3);
      for (int i = 0; i < 10; i++) run_line((i == 3) ? 10 : 0);
      // R11: change mid-frame, old frame must finish unchanged
      set_cfg(100, 120, 3, 6);
      for (int i = 0; i < 14; i++) run_line(0);
      // step 0 acts as 1, offset 0 gives no reset row, high rows test bit order
      set_cfg(1020, 1023, 0, 0);
      for (int i = 0; i < 10; i++) run_line((i == 5) ? 20 : 0);
      // inverted window: single-row frame, offset not below line count
      set_cfg(40, 30, 2, 1);
      for (int i = 0; i < 6; i++) run_line(0);
      // subsampled window with maximal offset
      set_cfg(200, 215, 5, 3);
      for (int i = 0; i < 9; i++) run_line(0);

      summary();
      $finish;
   end
endmodule